// File: doc/BRIEF.md
# Floating-Point Ordering Comparator

This block decides the order of two packed binary floating-point words. Each word holds a sign bit at the top, a biased exponent below it and a fraction field at the bottom. Because the exponent sits above the fraction, two magnitudes can be ordered with one unsigned integer compare of everything below the sign bit. The block builds on that compare. It then corrects the result for differing signs, for two negative operands, and for the two encodings of zero.

A result comes out one clock after the operands are presented. The result is one of four mutually exclusive flags: less-than, equal, greater-than, or unordered. Normalized numbers and zero are ordered. Any operand whose exponent field is all ones (infinity or NaN) makes the pair unordered. Values whose exponent field is zero are treated as zero, whatever their fraction. The exponent and fraction widths are parameters. The defaults give the 32-bit single-precision layout: sign in bit 31, exponent in bits 30:23 with a bias of 127, and fraction in bits 22:0. A normalized value equals (-1)^sign × (1 + fraction) × 2^(exponent − bias).

Top module: `fp_order_cmp`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_valid is 0 after that edge, even if in_valid is high.
- R2: Operands are captured on a rising edge where in_valid is 1, and the matching flags appear after that edge with out_valid at 1. After an edge where in_valid is 0, out_valid is 0 and the four flags keep their previous values. Operands may be presented on back-to-back cycles.
- R3: Whenever out_valid is 1, exactly one of a_lt_b, a_eq_b, a_gt_b and unordered is 1.
- R4: For two positive normalized operands, a larger exponent field gives the larger value. With equal exponent fields, a larger fraction gives the larger value.
- R5: When exactly one operand is negative and neither is zero, the negative operand is the smaller one.
- R6: When both operands are negative, the operand with the larger magnitude field (all bits below the sign) is the smaller one.
- R7: Any operand with exponent field 0 is zero, whatever its sign or fraction. Two such operands compare equal, and a zero orders above every negative value and below every positive value.
- R8: If either operand has an all-ones exponent field, unordered is 1 and a_lt_b, a_eq_b and a_gt_b are all 0.
- R9: Two identical ordered words compare equal.
- R10: In the default layout, the word 0xC0F00000 (sign 1, exponent 129, fraction .111 in binary) has the value -7.5. It orders below -3.75 (0xC0700000) and above -15 (0xC1700000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands on a_word and b_word are to be compared |
| a_word | input | 1+EXP_W+FRAC_W | First operand (32 by default) |
| b_word | input | 1+EXP_W+FRAC_W | Second operand (32 by default) |
| out_valid | output | 1 | Flags hold the result of the last captured pair |
| a_lt_b | output | 1 | First operand is smaller |
| a_eq_b | output | 1 | Operands are equal |
| a_gt_b | output | 1 | First operand is larger |
| unordered | output | 1 | At least one operand is infinity or NaN |

## Verification
The bench builds the block twice. The first copy uses the default 8-bit exponent and 23-bit fraction. It covers the single-precision worked value and the corner words where the exponent and the fraction trade off against each other. The second copy uses a 5-bit exponent and a 10-bit fraction. It shows that the field slicing, the zero and special detection, and the sign correction follow the parameters rather than fixed bit positions. Expected results come from decoding each word to a real number in the bench and comparing those numbers.

// File: rtl/fp_order_pkg.sv
// Package: shared result type for the floating-point ordering comparator.
// Assumes: the four outcomes are mutually exclusive.
package fp_order_pkg;

    // One-hot outcome of a comparison
    typedef struct packed {
        logic lt;
        logic eq;
        logic gt;
        logic un;
    } order_flags_t;

    localparam order_flags_t FLAGS_CLEAR = '{lt: 1'b0, eq: 1'b0, gt: 1'b0, un: 1'b0};

endpackage

// File: rtl/fp_operand_class.sv
// Module: fp_operand_class
// Splits one packed floating-point word into its fields and classifies it.
// A zero exponent field means zero: the magnitude and effective sign become 0,
// so both zero encodings and flushed small values look identical downstream.
// An all-ones exponent field marks the operand as special (infinity or NaN).
// Assumes the layout {sign, exponent[EXP_W], fraction[FRAC_W]}.
module fp_operand_class #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0]   word,
    output logic                    sign_eff,
    output logic [EXP_W+FRAC_W-1:0] mag_eff,
    output logic                    is_zero,
    output logic                    is_special
);
    localparam int MAG_W = EXP_W + FRAC_W;

    logic [EXP_W-1:0] exp_field;

    // Field extraction
    assign exp_field = word[MAG_W-1:FRAC_W];

    // Classification and zero canonicalisation
    always_comb begin
        is_zero    = (exp_field == '0);
        is_special = (exp_field == '1);
        sign_eff   = is_zero ? 1'b0 : word[MAG_W];
        mag_eff    = is_zero ? '0 : word[MAG_W-1:0];
    end
endmodule

// File: rtl/fp_order_core.sv
// Module: fp_order_core
// Combinational ordering of two classified operands. One unsigned compare of
// the magnitude fields orders the values, because the exponent sits above
// the fraction. The sign then patches that result: differing signs decide
// directly, and two negative operands swap less-than and greater-than.
// Assumes zero operands arrive with sign 0 and magnitude 0.
module fp_order_core
    import fp_order_pkg::*;
#(
    parameter int MAG_W = 31
) (
    input  logic             sign_a,
    input  logic             sign_b,
    input  logic [MAG_W-1:0] mag_a,
    input  logic [MAG_W-1:0] mag_b,
    input  logic             special_a,
    input  logic             special_b,
    output order_flags_t     flags
);
    logic mag_lt;
    logic mag_eq;

    // Unsigned magnitude compare
    always_comb begin
        mag_lt = (mag_a < mag_b);
        mag_eq = (mag_a == mag_b);
    end

    // Sign correction and special-value override
    always_comb begin
        flags = FLAGS_CLEAR;
        if (special_a || special_b) begin
            flags.un = 1'b1;
        end else if (sign_a != sign_b) begin
            flags.lt = sign_a;
            flags.gt = sign_b;
        end else if (mag_eq) begin
            flags.eq = 1'b1;
        end else if (sign_a) begin
            flags.lt = !mag_lt;
            flags.gt = mag_lt;
        end else begin
            flags.lt = mag_lt;
            flags.gt = !mag_lt;
        end
    end
endmodule

// File: rtl/fp_order_stage.sv
// Module: fp_order_stage
// Output register stage: captures the flags when in_valid is high and raises
// out_valid for the next cycle. With in_valid low the flags hold their value.
// Assumes a synchronous active-low reset that clears only out_valid and flags.
module fp_order_stage
    import fp_order_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  order_flags_t flags_d,
    output logic         out_valid,
    output order_flags_t flags_q
);
    // Valid bit register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Flag register, loaded only on accepted operands
    always_ff @(posedge clk) begin
        if (!rst_n)        flags_q <= FLAGS_CLEAR;
        else if (in_valid) flags_q <= flags_d;
    end

    // R1: reset clears out_valid at the next edge
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R2: an accepted pair yields a result one cycle later
    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: no input, no result, and the flags hold
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(flags_q)));

    // R3: one outcome per result
    a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({flags_q.lt, flags_q.eq, flags_q.gt, flags_q.un}) == 1));
endmodule

// File: rtl/fp_order_cmp.sv
// Module: fp_order_cmp (top)
// Orders two packed floating-point words with one cycle of latency.
// Two operand classifiers feed a combinational ordering core, and a register
// stage holds the result. Infinity and NaN give the unordered outcome only.
// Assumes exponent field 0 means zero (small values are flushed).
module fp_order_cmp #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [EXP_W+FRAC_W:0]   a_word,
    input  logic [EXP_W+FRAC_W:0]   b_word,
    output logic                    out_valid,
    output logic                    a_lt_b,
    output logic                    a_eq_b,
    output logic                    a_gt_b,
    output logic                    unordered
);
    import fp_order_pkg::*;

    localparam int MAG_W  = EXP_W + FRAC_W;
    localparam int WORD_W = MAG_W + 1;

    logic [WORD_W-1:0] words     [2];
    logic              sign_eff  [2];
    logic [MAG_W-1:0]  mag_eff   [2];
    logic              zero_flag [2];
    logic              spec_flag [2];

    order_flags_t flags_d;
    order_flags_t flags_q;

    // Operand fan-in for the classifier array
    assign words[0] = a_word;
    assign words[1] = b_word;

    // One classifier per operand
    for (genvar i = 0; i < 2; i++) begin : g_class
        fp_operand_class #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_class (
            .word       (words[i]),
            .sign_eff   (sign_eff[i]),
            .mag_eff    (mag_eff[i]),
            .is_zero    (zero_flag[i]),
            .is_special (spec_flag[i])
        );
    end

    fp_order_core #(
        .MAG_W (MAG_W)
    ) u_core (
        .sign_a    (sign_eff[0]),
        .sign_b    (sign_eff[1]),
        .mag_a     (mag_eff[0]),
        .mag_b     (mag_eff[1]),
        .special_a (spec_flag[0]),
        .special_b (spec_flag[1]),
        .flags     (flags_d)
    );

    fp_order_stage u_stage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .flags_d   (flags_d),
        .out_valid (out_valid),
        .flags_q   (flags_q)
    );

    // Result flags to ports
    always_comb begin
        a_lt_b    = flags_q.lt;
        a_eq_b    = flags_q.eq;
        a_gt_b    = flags_q.gt;
        unordered = flags_q.un;
    end

    // R8: an all-ones exponent on either input forces the unordered outcome
    a_r8_special_unordered: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (a_word[MAG_W-1:FRAC_W] == '1 || b_word[MAG_W-1:FRAC_W] == '1))
        |=> (unordered && !a_lt_b && !a_eq_b && !a_gt_b));

    // R7: two zero-exponent operands are equal regardless of sign or fraction
    a_r7_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_word[MAG_W-1:FRAC_W] == '0 && b_word[MAG_W-1:FRAC_W] == '0)
        |=> a_eq_b);

    // R5: a non-zero negative orders below a non-zero positive
    a_r5_sign_order: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_word[MAG_W] && !b_word[MAG_W]
         && a_word[MAG_W-1:FRAC_W] != '0 && b_word[MAG_W-1:FRAC_W] != '0
         && a_word[MAG_W-1:FRAC_W] != '1 && b_word[MAG_W-1:FRAC_W] != '1)
        |=> a_lt_b);

    // R9: identical ordered words are equal
    a_r9_same_word: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && a_word == b_word && a_word[MAG_W-1:FRAC_W] != '1)
        |=> a_eq_b);
endmodule

// File: tb/fp_order_cmp_tb.sv
module fp_order_cmp_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [31:0] a_w = '0, b_w = '0;
    logic [15:0] ha_w = '0, hb_w = '0;
    logic ov, lt, eq, gt, un;
    logic hov, hlt, heq, hgt, hun;
    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fp_order_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_word(a_w), .b_word(b_w),
        .out_valid(ov), .a_lt_b(lt), .a_eq_b(eq), .a_gt_b(gt), .unordered(un));

    fp_order_cmp #(.EXP_W(5), .FRAC_W(10)) u_dut_half (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a_word(ha_w), .b_word(hb_w),
        .out_valid(hov), .a_lt_b(hlt), .a_eq_b(heq), .a_gt_b(hgt), .unordered(hun));

    function automatic logic is_spec(input logic [31:0] w, input int ew, input int fw);
        return ((w >> fw) & ((1 << ew) - 1)) == ((1 << ew) - 1);
    endfunction

    // Value of a word from the stated layout
    function automatic real decode(input logic [31:0] w, input int ew, input int fw);
        int  e    = int'((w >> fw) & ((1 << ew) - 1));
        int  bias = (1 << (ew - 1)) - 1;
        real v;
        if (e == 0) return 0.0;
        v = 1.0 + real'(w & ((1 << fw) - 1)) / real'(1 << fw);
        for (int k = 0; k < e - bias; k++) v = v * 2.0;
        for (int k = 0; k < bias - e; k++) v = v / 2.0;
        return w[ew + fw] ? -v : v;
    endfunction

    function automatic logic [3:0] expect_flags(input logic [31:0] a, input logic [31:0] b,
                                                input int ew, input int fw);
        real va, vb;
        if (is_spec(a, ew, fw) || is_spec(b, ew, fw)) return 4'b0001;
        va = decode(a, ew, fw);
        vb = decode(b, ew, fw);
        if (va < vb) return 4'b1000;
        if (va == vb) return 4'b0100;
        return 4'b0010;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one pair to the chosen copy and check the flags after one edge
    task automatic cmp(input bit half, input logic [31:0] a, input logic [31:0] b, input string req);
        logic [3:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        if (half) begin ha_w = a[15:0]; hb_w = b[15:0]; end
        else begin a_w = a; b_w = b; end
        e = half ? expect_flags(a, b, 5, 10) : expect_flags(a, b, 8, 23);
        @(negedge clk);
        in_valid = 1'b0;
        if (half) check(req, {27'd0, hov, hlt, heq, hgt, hun}, {27'd0, 1'b1, e});
        else      check(req, {27'd0, ov, lt, eq, gt, un}, {27'd0, 1'b1, e});
    endtask

    task automatic t_reset;
        check("R1 idle reset", {31'd0, ov}, 32'd0);
        @(negedge clk); in_valid = 1'b1; a_w = 32'h3F800000; b_w = 32'h40000000;
        @(negedge clk);
        check("R1 valid during reset", {31'd0, ov}, 32'd0);
        in_valid = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {31'd0, ov}, 32'd0);
    endtask

    task automatic t_positive;
        cmp(0, 32'h3F800000, 32'h40000000, "R4 exponent 1.0<2.0");
        cmp(0, 32'h3FC00000, 32'h3FA00000, "R4 fraction 1.5>1.25");
        cmp(0, 32'h40000000, 32'h3FFFFFFF, "R4 exponent beats full fraction");
        check("R4 gt flag", {31'd0, gt}, 32'd1);
    endtask

    task automatic t_sign;
        cmp(0, 32'hBF800000, 32'h00800000, "R5 -1 < smallest normal");
        cmp(0, 32'h7F000000, 32'hFF000000, "R5 big pos > big neg");
    endtask

    task automatic t_negative;
        cmp(0, 32'hBF800000, 32'hC0000000, "R6 -1 > -2");
        cmp(0, 32'hBFA00000, 32'hBFC00000, "R6 -1.25 > -1.5");
    endtask

    task automatic t_zero;
        cmp(0, 32'h00000000, 32'h80000000, "R7 +0 == -0");
        cmp(0, 32'h00000001, 32'h80000000, "R7 flushed small == -0");
        check("R7 eq flag", {31'd0, eq}, 32'd1);
        cmp(0, 32'h80000000, 32'hBF800000, "R7 zero > -1");
        cmp(0, 32'h00000000, 32'h00800000, "R7 zero < smallest normal");
    endtask

    task automatic t_special;
        cmp(0, 32'h7F800000, 32'h3F800000, "R8 infinity unordered");
        cmp(0, 32'h3F800000, 32'h7FC00000, "R8 NaN unordered");
        check("R8 no order flag", {29'd0, lt, eq, gt}, 32'd0);
    endtask

    task automatic t_equal;
        cmp(0, 32'h40490FDB, 32'h40490FDB, "R9 same positive");
        cmp(0, 32'hC2F60000, 32'hC2F60000, "R9 same negative");
    endtask

    task automatic t_worked;
        n_checks++;
        if (decode(32'hC0F00000, 8, 23) != -7.5) begin
            n_fail++;
            $display("FAIL R10 decode actual=%f expected=-7.5", decode(32'hC0F00000, 8, 23));
        end
        cmp(0, 32'hC0F00000, 32'hC0700000, "R10 -7.5 < -3.75");
        check("R10 lt flag", {31'd0, lt}, 32'd1);
        cmp(0, 32'hC0F00000, 32'hC1700000, "R10 -7.5 > -15");
        check("R10 gt flag", {31'd0, gt}, 32'd1);
    endtask

    task automatic t_stream;
        logic prev;
        @(negedge clk); in_valid = 1'b1; a_w = 32'h3F800000; b_w = 32'h40000000;
        @(negedge clk); a_w = 32'h40000000; b_w = 32'h3F800000;
        check("R2 first of pair", {27'd0, ov, lt, eq, gt, un}, 32'h18);
        @(negedge clk); in_valid = 1'b0; a_w = 32'hBF800000;
        check("R2 second of pair", {27'd0, ov, lt, eq, gt, un}, 32'h12);
        prev = gt;
        @(negedge clk);
        check("R2 idle hold", {27'd0, ov, lt, eq, gt, un}, {27'd0, 1'b0, 1'b0, 1'b0, prev, 1'b0});
    endtask

    task automatic t_half;
        cmp(1, 32'h3C00, 32'h4000, "R4 half 1.0<2.0");
        cmp(1, 32'hBC00, 32'hC000, "R6 half -1 > -2");
        cmp(1, 32'h8000, 32'h0001, "R7 half zeros equal");
        cmp(1, 32'h7C00, 32'h3C00, "R8 half infinity");
        cmp(1, 32'hC000, 32'h3C00, "R5 half neg < pos");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_positive();
        t_sign();
        t_negative();
        t_zero();
        t_special();
        t_equal();
        t_worked();
        t_stream();
        t_half();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule